// File: doc/BRIEF.md
# Calibration Coefficient Loader with Whole-Set Retry

This block fetches a fixed set of calibration coefficients from a host processor during start-up. It is the master of a small byte bus. It drives a strobe, a one-bit address that selects status or data, a direction line and a write-data byte. The host answers with a read-data byte and a hold input. Each attempt begins with one status write, called the header. The header is followed by reads of every coefficient byte pair: a primary byte and then its back-up copy. Consecutive bus transfers are always separated by a fixed idle gap. During the gap the host can prepare the next byte.

When every back-up byte equals its primary, the primaries become the coefficient outputs. If any pair differs, the block raises its retry-request bit and sends a header with that bit set. It then reads the whole set again. If the third attempt still holds a mismatch, the block gives up. It zeroes the coefficients, which means no gain and no offset correction. It sets a sticky fail flag and reports completion, so normal operation can start.

The hold input is the host's only means of back-pressure. The block samples it on each rising clock edge while the strobe is high. The transfer lasts as long as hold is sampled high. The host may stretch any transfer for any number of cycles. It may also keep hold low all the time, in which case every transfer is one cycle long.

Top module: `cal_loader`

## Requirements
- R1: While the strobe is high, a rising edge that samples `host_hold` high keeps the transfer going. The first edge that samples it low ends the transfer, so the strobe is high for (cycles held + 1) cycles.
- R2: A read captures `bus_rdata` at the edge that ends the transfer. Values presented while hold is high are ignored.
- R3: Between any two consecutive transfers the strobe is low for exactly GAP_CYCLES cycles (default 15).
- R4: Each attempt is one status write (`bus_addr`=0, `bus_rd`=0) followed by 2*NUM_COEF reads (`bus_addr`=1, `bus_rd`=1). Default NUM_COEF is 22, giving 44 reads. Read number 2k is the primary of coefficient k and read 2k+1 is its back-up.
- R5: The status byte uses bit 0 for initialisation in progress, bit 1 for the retry request and bit 2 for fail. The first header after reset is 0x01.
- R6: If any pair mismatches and attempts remain, `cal_datrdy` goes high and the next header is 0x03. The full set is then read again.
- R7: If the attempt numbered MAX_TRIES (default 3) has a mismatch, the block sets `cal_fail`, which stays set. It forces all coefficients to zero, writes a final status of 0x04 and asserts `load_done`.
- R8: On an attempt with no mismatch, coefficient k on `coef_flat[8k+7:8k]` equals read 2k. The block then writes a final status of 0x00, asserts `load_done` and leaves `cal_datrdy` low.
- R9: A synchronous active-high `rst` holds the strobe low, clears all outputs and clears the attempt count. It restarts the sequence from the first header.
- R10: A mismatch in any single pair fails the attempt, including the last pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | 1 | 0 selects status, 1 selects coefficient data |
| bus_rd | output | 1 | 1 for a read from the host, 0 for a status write |
| bus_strobe | output | 1 | High while a transfer is active |
| bus_wdata | output | DATA_W | Status byte driven during writes |
| bus_rdata | input | DATA_W | Coefficient byte from the host |
| host_hold | input | 1 | Host holds high to stretch the current transfer |
| coef_flat | output | NUM_COEF*DATA_W | Coefficient register file, coefficient k in bits [8k+7:8k] |
| load_done | output | 1 | Loading finished, by pass or by fail |
| cal_datrdy | output | 1 | A retry of the whole set has been requested |
| cal_fail | output | 1 | All attempts failed and the coefficients were zeroed |

## Verification
The hardest case to reach from the ports is the third consecutive failed attempt. It only arises after two full retry cycles, each of 45 transfers. The bench's host model corrupts one back-up byte in a chosen number of attempts, counting attempts by the headers it sees. This drives the block through zero, one, two and three failures. Resetting midway through a retry, then requiring two more failures to still end in a pass, shows that the attempt count was cleared.

// File: rtl/cal_loader_pkg.sv
package cal_loader_pkg;
  localparam int STAT_INIT_BIT  = 0;
  localparam int STAT_RETRY_BIT = 1;
  localparam int STAT_FAIL_BIT  = 2;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_ACTIVE,
    XF_GAP
  } xfer_state_e;

  typedef enum logic [2:0] {
    CS_HEADER,
    CS_FETCH,
    CS_EVAL,
    CS_FINAL,
    CS_DONE
  } ctrl_state_e;
endpackage

// File: rtl/cal_xfer_engine.sv
module cal_xfer_engine
  import cal_loader_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int GAP_CYCLES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_read,
  input  logic              req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              host_hold,
  input  logic [DATA_W-1:0] host_rdata,
  output logic              bus_strobe,
  output logic              bus_rd,
  output logic              bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              xfer_done,
  output logic [DATA_W-1:0] xfer_rdata
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam int CW = $clog2(GAP_CYCLES + 2);

  xfer_state_e       st_q;
  logic [GW-1:0]     gap_q;
  logic              launch;
  logic              rd_q, addr_q;
  logic [DATA_W-1:0] wdata_q;

  // a transfer starts from idle, or straight out of the last gap cycle
  always_comb begin
    launch = 1'b0;
    if (req) begin
      if (st_q == XF_IDLE) launch = 1'b1;
      if (st_q == XF_GAP && gap_q == '0) launch = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= XF_IDLE;
      gap_q <= '0;
    end else begin
      case (st_q)
        XF_IDLE: if (launch) st_q <= XF_ACTIVE;
        XF_ACTIVE: begin
          if (!host_hold) begin
            st_q  <= XF_GAP;
            gap_q <= GW'(GAP_CYCLES - 1);
          end
        end
        XF_GAP: begin
          if (gap_q == '0) st_q <= launch ? XF_ACTIVE : XF_IDLE;
          else gap_q <= gap_q - 1'b1;
        end
        default: st_q <= XF_IDLE;
      endcase
    end
  end

  // bus fields are frozen for the whole transfer
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      addr_q  <= 1'b0;
      wdata_q <= '0;
    end else if (launch) begin
      rd_q    <= req_read;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign bus_strobe = (st_q == XF_ACTIVE);
  assign bus_rd     = rd_q;
  assign bus_addr   = addr_q;
  assign bus_wdata  = wdata_q;
  assign xfer_done  = (st_q == XF_ACTIVE) && !host_hold;
  assign xfer_rdata = host_rdata;

  // independent count of strobe-low cycles for the gap check
  logic [CW-1:0] low_cnt;
  logic          seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      seen_q  <= 1'b0;
    end else if (bus_strobe) begin
      low_cnt <= '0;
      seen_q  <= 1'b1;
    end else if (low_cnt != CW'(GAP_CYCLES + 1)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  a_r1_hold_stretches: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && host_hold) |=> bus_strobe);
  a_r1_low_ends: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && !host_hold) |=> !bus_strobe);
  a_r3_exact_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_strobe) && seen_q) |-> (low_cnt == CW'(GAP_CYCLES)));
  a_r4_fields_steady: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && host_hold) |=> ($stable(bus_wdata) && $stable(bus_addr) && $stable(bus_rd)));
endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank #(
  parameter int DATA_W   = 8,
  parameter int NUM_COEF = 22
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(2*NUM_COEF)-1:0] wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       clr_coef,
  input  logic                       clr_mism,
  output logic [NUM_COEF*DATA_W-1:0] coef_flat,
  output logic                       mism
);
  localparam int IW = $clog2(2 * NUM_COEF);

  logic [NUM_COEF-1:0] pair_bad;
  logic                mism_q;

  for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
    logic [DATA_W-1:0] val_q;
    logic              is_pri, is_bak;
    assign is_pri = wr_en && (wr_idx == IW'(2 * k));
    assign is_bak = wr_en && (wr_idx == IW'(2 * k + 1));
    always_ff @(posedge clk) begin
      if (rst || clr_coef) val_q <= '0;
      else if (is_pri)     val_q <= wr_data;
    end
    assign pair_bad[k] = is_bak && (wr_data != val_q);
    assign coef_flat[k*DATA_W +: DATA_W] = val_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_mism)  mism_q <= 1'b0;
    else if (|pair_bad)   mism_q <= 1'b1;
  end
  assign mism = mism_q;

  a_r7_zeroed: assert property (@(posedge clk) disable iff (rst)
    clr_coef |=> (coef_flat == '0));
  a_r10_mismatch_sticky: assert property (@(posedge clk) disable iff (rst)
    (mism && !clr_mism) |=> mism);
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_loader_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_COEF  = 22,
  parameter int MAX_TRIES = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          xfer_done,
  input  logic                          mism,
  output logic                          req,
  output logic                          req_read,
  output logic                          req_addr,
  output logic [DATA_W-1:0]             req_wdata,
  output logic                          wr_en,
  output logic [$clog2(2*NUM_COEF)-1:0] wr_idx,
  output logic                          clr_coef,
  output logic                          clr_mism,
  output logic                          load_done,
  output logic                          cal_datrdy,
  output logic                          cal_fail
);
  localparam int NBYTES = 2 * NUM_COEF;
  localparam int IW     = $clog2(NBYTES);
  localparam int TW     = $clog2(MAX_TRIES + 1);

  ctrl_state_e   st_q;
  logic [IW-1:0] idx_q;
  logic [TW-1:0] try_q;
  logic          datrdy_q, fail_q, last_try;

  assign last_try = (try_q == TW'(MAX_TRIES - 1));

  always_comb begin
    req       = (st_q == CS_HEADER) || (st_q == CS_FETCH) || (st_q == CS_FINAL);
    req_read  = (st_q == CS_FETCH);
    req_addr  = (st_q == CS_FETCH);
    req_wdata = '0;
    req_wdata[STAT_INIT_BIT]  = (st_q != CS_FINAL);
    req_wdata[STAT_RETRY_BIT] = datrdy_q;
    req_wdata[STAT_FAIL_BIT]  = fail_q;
  end

  assign wr_en  = xfer_done && (st_q == CS_FETCH);
  assign wr_idx = idx_q;

  always_comb begin
    clr_coef = 1'b0;
    clr_mism = 1'b0;
    if (st_q == CS_EVAL && mism) begin
      if (last_try) clr_coef = 1'b1;
      else          clr_mism = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= CS_HEADER;
      idx_q    <= '0;
      try_q    <= '0;
      datrdy_q <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      case (st_q)
        CS_HEADER: begin
          if (xfer_done) begin
            st_q  <= CS_FETCH;
            idx_q <= '0;
          end
        end
        CS_FETCH: begin
          if (xfer_done) begin
            if (idx_q == IW'(NBYTES - 1)) st_q <= CS_EVAL;
            else                          idx_q <= idx_q + 1'b1;
          end
        end
        CS_EVAL: begin
          if (!mism) begin
            st_q     <= CS_FINAL;
            datrdy_q <= 1'b0;
          end else if (last_try) begin
            st_q     <= CS_FINAL;
            fail_q   <= 1'b1;
            datrdy_q <= 1'b0;
          end else begin
            st_q     <= CS_HEADER;
            try_q    <= try_q + 1'b1;
            datrdy_q <= 1'b1;
          end
        end
        CS_FINAL: if (xfer_done) st_q <= CS_DONE;
        CS_DONE:  st_q <= CS_DONE;
        default:  st_q <= CS_DONE;
      endcase
    end
  end

  assign load_done  = (st_q == CS_DONE);
  assign cal_datrdy = datrdy_q;
  assign cal_fail   = fail_q;

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    cal_fail |=> cal_fail);
  a_r9_try_bound: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (try_q < TW'(MAX_TRIES)));
  a_r8_done_no_retry: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !cal_datrdy);
  a_r6_retry_header: assert property (@(posedge clk) disable iff (rst)
    (st_q == CS_HEADER && try_q != '0) |-> cal_datrdy);
endmodule

// File: rtl/cal_loader.sv
module cal_loader #(
  parameter int DATA_W     = 8,
  parameter int NUM_COEF   = 22,
  parameter int GAP_CYCLES = 15,
  parameter int MAX_TRIES  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic                       bus_addr,
  output logic                       bus_rd,
  output logic                       bus_strobe,
  output logic [DATA_W-1:0]          bus_wdata,
  input  logic [DATA_W-1:0]          bus_rdata,
  input  logic                       host_hold,
  output logic [NUM_COEF*DATA_W-1:0] coef_flat,
  output logic                       load_done,
  output logic                       cal_datrdy,
  output logic                       cal_fail
);
  localparam int IW = $clog2(2 * NUM_COEF);

  logic              req, req_read, req_addr;
  logic [DATA_W-1:0] req_wdata, xfer_rdata;
  logic              xfer_done, wr_en, clr_coef, clr_mism, mism;
  logic [IW-1:0]     wr_idx;

  cal_xfer_engine #(.DATA_W(DATA_W), .GAP_CYCLES(GAP_CYCLES)) u_eng (
    .clk(clk), .rst(rst),
    .req(req), .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .host_hold(host_hold), .host_rdata(bus_rdata),
    .bus_strobe(bus_strobe), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .xfer_done(xfer_done), .xfer_rdata(xfer_rdata)
  );

  cal_seq_ctrl #(.DATA_W(DATA_W), .NUM_COEF(NUM_COEF), .MAX_TRIES(MAX_TRIES)) u_ctrl (
    .clk(clk), .rst(rst),
    .xfer_done(xfer_done), .mism(mism),
    .req(req), .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .clr_coef(clr_coef), .clr_mism(clr_mism),
    .load_done(load_done), .cal_datrdy(cal_datrdy), .cal_fail(cal_fail)
  );

  cal_coef_bank #(.DATA_W(DATA_W), .NUM_COEF(NUM_COEF)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(xfer_rdata),
    .clr_coef(clr_coef), .clr_mism(clr_mism),
    .coef_flat(coef_flat), .mism(mism)
  );
endmodule

// File: tb/cal_loader_test.sv
module cal_loader_test;
  localparam int NC  = 22;
  localparam int GAP = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_hold = 1'b0;
  logic [7:0]    bus_rdata = '0;
  logic          bus_addr, bus_rd, bus_strobe, load_done, cal_datrdy, cal_fail;
  logic [7:0]    bus_wdata;
  logic [NC*8-1:0] coef_flat;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  int status_log [16];
  int dr_log [16];
  int n_stat, n_read, gap_bad, len_bad, addr_bad;

  always #4 clk = ~clk;

  cal_loader uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_strobe(bus_strobe),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_hold(host_hold),
    .coef_flat(coef_flat), .load_done(load_done), .cal_datrdy(cal_datrdy), .cal_fail(cal_fail)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cval(input int seed, input int k);
    return 8'((seed * 7 + k * 37 + 3) & 255);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_hold = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // host model: serves transfers until load_done or cycle limit
  task automatic run_host(input int seed, input int bad_attempts, input int bad_idx,
                          input int stretch, input int max_cyc);
    bit prev = 0, seen_end = 0;
    int gap = 0, slen = 0, exp_len = 1, hold_left = 0, byte_i = 0;
    logic [7:0] cur = '0;
    n_stat = 0; n_read = 0; gap_bad = 0; len_bad = 0; addr_bad = 0;
    for (int cyc = 0; cyc < max_cyc; cyc++) begin
      @(negedge clk);
      if (bus_strobe && !prev) begin
        if (seen_end && gap != GAP) gap_bad++;
        gap = 0; slen = 0;
        if (!bus_rd) begin
          if (bus_addr !== 1'b0) addr_bad++;
          if (n_stat < 16) begin status_log[n_stat] = int'(bus_wdata); dr_log[n_stat] = int'(cal_datrdy); end
          n_stat++; byte_i = 0; hold_left = 0; exp_len = 1;
        end else begin
          if (bus_addr !== 1'b1) addr_bad++;
          cur = cval(seed, byte_i / 2);
          if ((byte_i % 2) == 1 && (n_stat - 1) < bad_attempts && (byte_i / 2) == bad_idx)
            cur = cur ^ 8'h10;
          hold_left = (stretch > 0 && (n_read % 4) == 1) ? stretch : 0;
          exp_len = hold_left + 1;
          byte_i++; n_read++;
        end
      end
      if (bus_strobe) begin
        slen++;
        if (hold_left > 0) begin host_hold = 1'b1; bus_rdata = ~cur; hold_left--; end
        else begin host_hold = 1'b0; bus_rdata = cur; end
      end else begin
        if (prev) begin
          if (slen != exp_len) len_bad++;
          seen_end = 1;
        end
        host_hold = 1'b0;
        gap++;
      end
      prev = bus_strobe;
      if (load_done) break;
    end
  endtask

  task automatic chk_coefs(input string tag, input int seed, input bit zero);
    int bad = 0;
    for (int k = 0; k < NC; k++) begin
      logic [7:0] e;
      e = zero ? 8'h00 : cval(seed, k);
      if (coef_flat[k*8 +: 8] != e) bad++;
    end
    chk(tag, "coefficient mismatches", bad, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9", "strobe in reset", bus_strobe, 0);
    chk("R9", "done in reset", load_done, 0);
    chk("R9", "fail in reset", cal_fail, 0);
    chk("R9", "datrdy in reset", cal_datrdy, 0);
    chk("R9", "coefs in reset", (coef_flat == '0), 1);
  endtask

  task automatic t_clean(input int seed);
    do_reset();
    run_host(seed, 0, 0, 0, 20000);
    chk("R4", "status writes", n_stat, 2);
    chk("R5", "first header", status_log[0], 8'h01);
    chk("R8", "final status", status_log[1], 8'h00);
    chk("R4", "reads", n_read, 2 * NC);
    chk("R4", "address errors", addr_bad, 0);
    chk("R3", "bad gaps", gap_bad, 0);
    chk("R1", "bad strobe lengths", len_bad, 0);
    chk("R8", "done", load_done, 1);
    chk("R8", "datrdy", cal_datrdy, 0);
    chk("R8", "fail", cal_fail, 0);
    chk_coefs("R8", seed, 0);
  endtask

  task automatic t_stretch(input int seed, input int s);
    do_reset();
    run_host(seed, 0, 0, s, 20000);
    chk("R1", "stretched strobe lengths", len_bad, 0);
    chk("R3", "gaps with stretch", gap_bad, 0);
    chk("R2", "done", load_done, 1);
    chk_coefs("R2", seed, 0);
  endtask

  task automatic t_retry(input int seed, input int nbad, input int idx);
    int att;
    att = (nbad + 1 < 3) ? nbad + 1 : 3;
    do_reset();
    run_host(seed, nbad, idx, 0, 20000);
    chk("R6", "status writes", n_stat, att + 1);
    chk("R6", "reads", n_read, 2 * NC * att);
    chk("R5", "first header", status_log[0], 8'h01);
    for (int i = 1; i < att; i++) begin
      chk("R6", "retry header", status_log[i], 8'h03);
      chk("R6", "datrdy at retry header", dr_log[i], 1);
    end
    chk("R3", "bad gaps", gap_bad, 0);
    chk("R10", "done", load_done, 1);
    if (nbad >= 3) begin
      chk("R7", "final status", status_log[att], 8'h04);
      chk("R7", "fail", cal_fail, 1);
      chk("R7", "datrdy", cal_datrdy, 0);
      chk_coefs("R7", seed, 1);
      @(negedge clk);
      chk("R7", "fail held", cal_fail, 1);
    end else begin
      chk("R8", "final status", status_log[att], 8'h00);
      chk("R8", "fail", cal_fail, 0);
      chk("R8", "datrdy", cal_datrdy, 0);
      chk_coefs("R8", seed, 0);
    end
  endtask

  task automatic t_reset_mid(input int seed);
    do_reset();
    run_host(seed, 2, 5, 0, 1000);
    chk("R9", "not done before reset", load_done, 0);
    chk("R6", "datrdy mid retry", cal_datrdy, 1);
    do_reset();
    run_host(seed, 2, 5, 0, 20000);
    chk("R9", "header after reset", status_log[0], 8'h01);
    chk("R9", "pass after two more failures", status_log[3], 8'h00);
    chk("R9", "fail", cal_fail, 0);
    chk_coefs("R9", seed, 0);
  endtask

  initial begin
    t_reset_state();
    t_clean(1);
    t_clean(9);
    t_stretch(4, 3);
    t_stretch(6, 1);
    t_retry(2, 1, 0);
    t_retry(3, 2, 11);
    t_retry(5, 3, 7);
    t_retry(8, 1, NC - 1);
    t_reset_mid(12);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule